// File: doc/BRIEF.md
# Latched Driver Fault Status

This block collects fault events reported by the monitors of a bank of output drivers. It keeps them as sticky flags in two 23-bit status words that the serial interface shifts out. Over-current and thermal flags turn into shutdown commands for the power stages. Each status word carries a summary bit that is low whenever any flag in either word is set, so the host can poll one bit instead of reading a whole frame.

The host clears all flags with a clear bit in its control word. The clear waits for the frame-end strobe, which comes from chip select rising, so the frame in flight still returns the flags as they stood. An over-current flag keeps its driver off until the host clears it. When recovery is enabled for that driver, the block releases the driver by itself after a fixed retry interval, while the flag stays set for reporting. A thermal shutdown flag turns every output off until the host clears it.

Top module: `fault_status`

## Requirements
- R1: After reset all flags are clear: `stat_a` and `stat_b` both read 1 (only bit 0 set), `drv_off` is 0 and `all_off` is 0.
- R2: A one-cycle event pulse sets its flag on the next clock edge, and the flag stays set until a clear. Field positions:
  - `stat_a` bits 1..NDRV hold the over-current flags of drivers 0..NDRV-1.
  - `stat_a` bit W-2 (21) holds thermal warning and bit W-1 (22) holds thermal shutdown.
  - `stat_b` bits 1..NDRV hold the open-load flags of drivers 0..NDRV-1.
  - All other bits of both words above bit 0 read 0.
- R3: Bit 0 of both words is the same. It is 1 exactly when every bit from 1 to W-1 of both words is 0.
- R4: When `frame_end` and `clr_req` are both high at a clock edge, all flags are clear after that edge. `clr_req` without `frame_end`, or `frame_end` without `clr_req`, leaves the flags unchanged.
- R5: An event that arrives in the same cycle as a clear is kept, so its flag is set after the edge.
- R6: While a driver's over-current flag is set and its `rec_en` bit is 0, that driver's `drv_off` bit is 1.
- R7: When `rec_en` is 1 for a driver, an over-current event holds its `drv_off` bit high for exactly RETRY cycles after the edge that latches the flag. The bit then drops while the flag stays set. A new event restarts the interval.
- R8: `all_off` is 1 exactly while the thermal shutdown flag is set. Thermal warning does not raise it.
- R9: Open-load flags never set `drv_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oc_evt | input | NDRV | Over-current event pulses, one per driver |
| ol_evt | input | NDRV | Open-load event pulses, one per driver |
| tw_evt | input | 1 | Thermal warning event pulse |
| tsd_evt | input | 1 | Thermal shutdown event pulse |
| rec_en | input | NDRV | Per-driver over-current recovery enable |
| clr_req | input | 1 | Clear-all bit from the latest control word |
| frame_end | input | 1 | One-cycle strobe at the end of a serial frame |
| stat_a | output | W | Status word A: summary, over-current, thermal flags |
| stat_b | output | W | Status word B: summary, open-load flags |
| drv_off | output | NDRV | Per-driver disable |
| all_off | output | 1 | Force all outputs to high impedance |

## Verification
The bench fires events in the same cycle as a clear. A design that gave the clear priority would lose those flags. It raises `clr_req` and `frame_end` separately, which would catch a clear that acts on either one alone. It counts the cycles for which a recovering driver is held off; an off-by-one counter load or a missing reload shows up there as a wrong count. Random events, recovery bits and clears run against a bench model. That model catches a summary bit that ignores one word, open-load flags that leak into `drv_off`, and a thermal warning that is mistaken for shutdown.

// File: rtl/fault_status.sv
module fault_status #(
  parameter int NDRV  = 11,
  parameter int W     = 23,
  parameter int RETRY = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDRV-1:0] oc_evt,
  input  logic [NDRV-1:0] ol_evt,
  input  logic            tw_evt,
  input  logic            tsd_evt,
  input  logic [NDRV-1:0] rec_en,
  input  logic            clr_req,
  input  logic            frame_end,
  output logic [W-1:0]    stat_a,
  output logic [W-1:0]    stat_b,
  output logic [NDRV-1:0] drv_off,
  output logic            all_off
);
  localparam int CW = $clog2(RETRY + 1);

  logic [NDRV-1:0] oc_q, ol_q;
  logic            tw_q, tsd_q;
  logic [CW-1:0]   cnt [NDRV];

  wire clr   = frame_end & clr_req;
  wire fault = |{oc_q, ol_q, tw_q, tsd_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q  <= '0;
      ol_q  <= '0;
      tw_q  <= 1'b0;
      tsd_q <= 1'b0;
    end else begin
      oc_q  <= (clr ? '0 : oc_q) | oc_evt;
      ol_q  <= (clr ? '0 : ol_q) | ol_evt;
      tw_q  <= (~clr & tw_q) | tw_evt;
      tsd_q <= (~clr & tsd_q) | tsd_evt;
    end
  end

  for (genvar i = 0; i < NDRV; i++) begin : g_drv
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt[i] <= '0;
      else if (oc_evt[i])     cnt[i] <= CW'(RETRY);
      else if (clr)           cnt[i] <= '0;
      else if (cnt[i] != '0)  cnt[i] <= cnt[i] - 1'b1;
    end
    assign drv_off[i] = oc_q[i] & (~rec_en[i] | (cnt[i] != '0));
  end

  always_comb begin
    stat_a          = '0;
    stat_a[0]       = ~fault;
    stat_a[NDRV:1]  = oc_q;
    stat_a[W-2]     = tw_q;
    stat_a[W-1]     = tsd_q;
    stat_b          = '0;
    stat_b[0]       = ~fault;
    stat_b[NDRV:1]  = ol_q;
  end

  assign all_off = tsd_q;
endmodule

// File: rtl/fault_status_chk.sv
module fault_status_chk #(
  parameter int NDRV = 11,
  parameter int W    = 23
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NDRV-1:0] oc_evt,
  input logic [NDRV-1:0] ol_evt,
  input logic            tw_evt,
  input logic            tsd_evt,
  input logic [NDRV-1:0] rec_en,
  input logic            clr_req,
  input logic            frame_end,
  input logic [W-1:0]    stat_a,
  input logic [W-1:0]    stat_b,
  input logic [NDRV-1:0] drv_off,
  input logic            all_off
);
  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_end && clr_req) |=>
      ((stat_a[W-1:1] & $past(stat_a[W-1:1])) == $past(stat_a[W-1:1])) &&
      ((stat_b[W-1:1] & $past(stat_b[W-1:1])) == $past(stat_b[W-1:1])));

  // R3
  summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_a[0] == stat_b[0]) &&
    (stat_a[0] == ((stat_a[W-1:1] == '0) && (stat_b[W-1:1] == '0))));

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && clr_req && oc_evt == '0 && ol_evt == '0 && !tw_evt && !tsd_evt) |=>
      (stat_a[W-1:1] == '0 && stat_b[W-1:1] == '0));

  // R5
  evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && clr_req && oc_evt[0]) |=> stat_a[1]);

  // R6
  latch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_a[NDRV:1] & ~rec_en & ~drv_off) == '0);

  // R8
  tsd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_off == stat_a[W-1]);

  // R9
  ol_no_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_off & ~stat_a[NDRV:1]) == '0);
endmodule

bind fault_status fault_status_chk #(.NDRV(NDRV), .W(W)) u_chk (.*);

// File: tb/fault_status_bench.sv
`timescale 1ns/1ps
module fault_status_bench;
  localparam int NDRV = 11, W = 23, RETRY = 64;

  logic clk = 0, rst_n = 0;
  logic [NDRV-1:0] oc_evt = '0, ol_evt = '0, rec_en = '0;
  logic tw_evt = 0, tsd_evt = 0, clr_req = 0, frame_end = 0;
  logic [W-1:0] stat_a, stat_b;
  logic [NDRV-1:0] drv_off;
  logic all_off;

  int checks = 0, errors = 0;
  logic [NDRV-1:0] m_oc = '0, m_ol = '0;
  logic m_tw = 0, m_tsd = 0;
  int m_cnt [NDRV];

  always #5 clk = ~clk;

  fault_status #(.NDRV(NDRV), .W(W), .RETRY(RETRY)) u_fault_status (.*);

  function automatic logic [W-1:0] exp_a();
    logic [W-1:0] a = '0;
    a[0] = ~|{m_oc, m_ol, m_tw, m_tsd};
    a[NDRV:1] = m_oc; a[W-2] = m_tw; a[W-1] = m_tsd;
    return a;
  endfunction

  function automatic logic [W-1:0] exp_b();
    logic [W-1:0] b = '0;
    b[0] = ~|{m_oc, m_ol, m_tw, m_tsd};
    b[NDRV:1] = m_ol;
    return b;
  endfunction

  function automatic logic [NDRV-1:0] exp_off();
    logic [NDRV-1:0] o;
    for (int i = 0; i < NDRV; i++) o[i] = m_oc[i] & (~rec_en[i] | (m_cnt[i] != 0));
    return o;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic model_next();
    logic c = frame_end & clr_req;
    for (int i = 0; i < NDRV; i++) begin
      if (oc_evt[i]) m_cnt[i] = RETRY;
      else if (c) m_cnt[i] = 0;
      else if (m_cnt[i] > 0) m_cnt[i]--;
    end
    m_oc  = (c ? '0 : m_oc) | oc_evt;
    m_ol  = (c ? '0 : m_ol) | ol_evt;
    m_tw  = (~c & m_tw) | tw_evt;
    m_tsd = (~c & m_tsd) | tsd_evt;
  endtask

  task automatic step();
    model_next();
    @(negedge clk);
    chk("R2/R3 stat_a", 32'(stat_a), 32'(exp_a()));
    chk("R2/R3 stat_b", 32'(stat_b), 32'(exp_b()));
    chk("R6/R7/R9 drv_off", 32'(drv_off), 32'(exp_off()));
    chk("R8 all_off", 32'(all_off), 32'(m_tsd));
  endtask

  task automatic quiet();
    oc_evt = '0; ol_evt = '0; tw_evt = 0; tsd_evt = 0; clr_req = 0; frame_end = 0;
  endtask

  task automatic do_clear();
    clr_req = 1; frame_end = 1; step(); quiet();
  endtask

  initial begin
    int held;
    void'($urandom(32'd7));
    for (int i = 0; i < NDRV; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset stat_a", 32'(stat_a), 32'd1);
    chk("R1 reset stat_b", 32'(stat_b), 32'd1);
    chk("R1 reset drv_off", 32'(drv_off), 32'd0);
    chk("R1 reset all_off", 32'(all_off), 32'd0);
    rst_n = 1;
    step();

    oc_evt[2] = 1; step(); quiet();
    repeat (RETRY + 5) step();
    chk("R2 oc flag sticky", 32'(stat_a[3]), 32'd1);
    chk("R3 summary low", 32'({stat_a[0], stat_b[0]}), 32'd0);
    chk("R6 latched off", 32'(drv_off[2]), 32'd1);

    clr_req = 1; step(); quiet();
    chk("R4 clr_req alone", 32'(stat_a[3]), 32'd1);
    frame_end = 1; step(); quiet();
    chk("R4 frame_end alone", 32'(stat_a[3]), 32'd1);
    do_clear(); step();
    chk("R4 cleared", 32'(stat_a), 32'd1);
    chk("R4 driver released", 32'(drv_off), 32'd0);

    oc_evt[0] = 1; ol_evt[4] = 1; clr_req = 1; frame_end = 1; step(); quiet();
    chk("R5 oc kept", 32'(stat_a[1]), 32'd1);
    chk("R5 ol kept", 32'(stat_b[5]), 32'd1);
    chk("R9 open load no off", 32'(drv_off[4]), 32'd0);
    do_clear();

    rec_en = '1; oc_evt[5] = 1; step(); quiet();
    held = drv_off[5] ? 1 : 0;
    repeat (RETRY + 4) begin step(); if (drv_off[5]) held++; end
    chk("R7 retry cycles", 32'(held), 32'(RETRY));
    chk("R7 flag stays", 32'(stat_a[6]), 32'd1);
    do_clear(); rec_en = '0;

    tw_evt = 1; step(); quiet();
    chk("R8 warning no off", 32'(all_off), 32'd0);
    chk("R2 warning bit", 32'(stat_a[W-2]), 32'd1);
    tsd_evt = 1; step(); quiet();
    repeat (20) step();
    chk("R8 shutdown held", 32'(all_off), 32'd1);
    do_clear();
    chk("R8 shutdown cleared", 32'(all_off), 32'd0);

    repeat (4000) begin
      for (int i = 0; i < NDRV; i++) begin
        oc_evt[i] = ($urandom % 60) == 0;
        ol_evt[i] = ($urandom % 60) == 0;
      end
      tw_evt = ($urandom % 90) == 0;
      tsd_evt = ($urandom % 150) == 0;
      if (($urandom % 50) == 0) rec_en = NDRV'($urandom);
      frame_end = ($urandom % 8) == 0;
      clr_req = ($urandom % 3) == 0;
      step();
    end
    quiet();
    step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule